// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches page table entries so that a 32-bit virtual address can be turned into a physical page frame without a walk through memory. Bits 31 to 9 of an address form the virtual page number. A lookup compares that number against every stored tag at once. One cycle after the request, the block reports hit or miss. On a hit it also returns the frame number, the page-valid bit, the modified bit and the pre-decoded protection field of the matching entry. Any entry may hold a page from process space or from system space.

On a miss, an external page walker fetches the entry and writes it in through the fill port. A new page goes into the slot chosen by a replacement pointer. That pointer steps forward whenever the slot it names is used, so the most recently used slot is never the one that gets evicted. Control-register writes drive the remaining operations: several selector codes flush the whole buffer, one code invalidates a single page, and one code probes for a page and leaves the answer on a flag output.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer names entry 0, and `lk_hit` and `probe_flag` are 0.
- R2: A lookup hits when a valid entry's tag equals `lk_va[31:9]`. Bits 8:0 take no part in the compare. One cycle after `lk_req`, `lk_hit` is 1 and the stored frame, page-valid, modified and protection fields appear on the outputs.
- R3: On a miss, or when no lookup was requested in the previous cycle, `lk_hit`, `lk_pfn`, `lk_pv`, `lk_mod` and `lk_prot` are all 0.
- R4: A fill whose page matches no valid entry is written into the entry named by the replacement pointer, and the pointer then moves to the next entry.
- R5: A lookup that hits the entry named by the replacement pointer advances the pointer by one. A hit on any other entry leaves the pointer where it is.
- R6: The replacement pointer steps from entry 27 back to entry 0.
- R7: A fill whose page already matches a valid entry overwrites that entry and creates no duplicate. The pointer moves only if that entry is the one it names.
- R8: A control write with `ctl_sel` equal to 0 (mapping enable), 1 (page-table base or length) or 2 (invalidate all) invalidates every entry, whatever the value of `ctl_data`.
- R9: A control write with `ctl_sel` = 3 invalidates every entry whose tag equals `ctl_data[31:9]` and leaves all other entries untouched.
- R10: A control write with `ctl_sel` = 4 sets `probe_flag` on the next cycle to 1 if a valid entry matches `ctl_data[31:9]`, and to 0 otherwise. The flag holds its value until the next probe write. A probe never changes any entry.
- R11: If a fill arrives in the same cycle as an invalidating control write (`ctl_sel` 0 to 3), the fill is discarded.
- R12: Control writes with `ctl_sel` of 5, 6 or 7 have no effect on any entry.
- R13: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered hit for the previous cycle's lookup |
| lk_pfn | output | 21 | Frame number of the hit entry |
| lk_pv | output | 1 | Page-valid bit of the hit entry |
| lk_mod | output | 1 | Modified bit of the hit entry |
| lk_prot | output | 8 | Pre-decoded protection field of the hit entry |
| fill_en | input | 1 | Write a new entry |
| fill_va | input | 32 | Virtual address of the page being filled |
| fill_pfn | input | 21 | Frame number to store |
| fill_pv | input | 1 | Page-valid bit to store |
| fill_mod | input | 1 | Modified bit to store |
| fill_prot | input | 8 | Protection field to store |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_sel | input | 3 | Control register select (0 to 4 used) |
| ctl_data | input | 32 | Control write data (virtual address for codes 3 and 4) |
| probe_flag | output | 1 | Result of the most recent probe |

## Verification
The collision that matters is a page-walker fill arriving in the same cycle as an invalidating control write. The bench provokes it by driving `fill_en` and `ctl_wr` on the same edge, once with a single-page invalidate aimed at a different, already stored page and once with a full flush. It judges the result by later lookups: the page carried by the fill must miss, and so must the page targeted by the invalidate. A second overlap, a lookup together with a fill of the same page, is judged by the lookup missing and a following lookup hitting.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 28,
  parameter int VA_W    = 32,
  parameter int PG_BITS = 9,
  parameter int PFN_W   = 21,
  parameter int PROT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_pv,
  output logic              lk_mod,
  output logic [PROT_W-1:0] lk_prot,
  input  logic              fill_en,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_pv,
  input  logic              fill_mod,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_sel,
  input  logic [VA_W-1:0]   ctl_data,
  output logic              probe_flag
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int DAT_W = PFN_W + 2 + PROT_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  localparam logic [2:0] SEL_MAPEN = 3'd0;
  localparam logic [2:0] SEL_BASE  = 3'd1;
  localparam logic [2:0] SEL_INVAL = 3'd2;
  localparam logic [2:0] SEL_INV1  = 3'd3;
  localparam logic [2:0] SEL_PROBE = 3'd4;

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [DAT_W-1:0] dat_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, m_lk, m_fl, m_ct;
  logic [PTR_W-1:0] ptr_q, lk_idx, fl_idx, wr_idx;
  logic [DAT_W-1:0] rd_dat;

  logic unused_lo;
  assign unused_lo = ^{lk_va[PG_BITS-1:0], fill_va[PG_BITS-1:0], ctl_data[PG_BITS-1:0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m_lk[g] = vld_q[g] && (tag_q[g] == lk_va[VA_W-1:PG_BITS]);
    assign m_fl[g] = vld_q[g] && (tag_q[g] == fill_va[VA_W-1:PG_BITS]);
    assign m_ct[g] = vld_q[g] && (tag_q[g] == ctl_data[VA_W-1:PG_BITS]);
  end

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_lk[i]) lk_idx = PTR_W'(i);
      if (m_fl[i]) fl_idx = PTR_W'(i);
    end
  end

  wire flush    = ctl_wr && (ctl_sel == SEL_MAPEN || ctl_sel == SEL_BASE || ctl_sel == SEL_INVAL);
  wire inv_one  = ctl_wr && (ctl_sel == SEL_INV1);
  wire probe    = ctl_wr && (ctl_sel == SEL_PROBE);
  wire fill_go  = fill_en && !flush && !inv_one;
  wire lk_any   = lk_req && (|m_lk);
  assign wr_idx = (|m_fl) ? fl_idx : ptr_q;
  wire adv      = (lk_req && m_lk[ptr_q]) || (fill_go && wr_idx == ptr_q);
  assign rd_dat = dat_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      if (flush) vld_q <= '0;
      else begin
        if (inv_one) vld_q <= vld_q & ~m_ct;
        if (fill_go) vld_q[wr_idx] <= 1'b1;
      end
      if (adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[wr_idx] <= fill_va[VA_W-1:PG_BITS];
      dat_q[wr_idx] <= {fill_pfn, fill_pv, fill_mod, fill_prot};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit     <= 1'b0;
      {lk_pfn, lk_pv, lk_mod, lk_prot} <= '0;
      probe_flag <= 1'b0;
    end else begin
      lk_hit <= lk_any;
      {lk_pfn, lk_pv, lk_mod, lk_prot} <= lk_any ? rd_dat : '0;
      if (probe) probe_flag <= |m_ct;
    end
  end

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_req) |-> !lk_hit); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0 && !lk_pv && !lk_mod && lk_prot == '0)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> vld_q == '0); // R8
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q != $past(ptr_q) |-> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + PTR_W'(1))); // R5
  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_lk)); // R7
endmodule

// File: tb/sim_tlb_assoc.sv
module sim_tlb_assoc;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, fill_en = 0, ctl_wr = 0;
  logic [31:0] lk_va = 0, fill_va = 0, ctl_data = 0;
  logic [20:0] fill_pfn = 0;
  logic fill_pv = 0, fill_mod = 0;
  logic [7:0] fill_prot = 0;
  logic [2:0] ctl_sel = 0;
  logic lk_hit, lk_pv, lk_mod, probe_flag;
  logic [20:0] lk_pfn;
  logic [7:0] lk_prot;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_assoc u0 (.clk, .rst_n, .lk_req, .lk_va, .lk_hit, .lk_pfn, .lk_pv, .lk_mod, .lk_prot,
    .fill_en, .fill_va, .fill_pfn, .fill_pv, .fill_mod, .fill_prot,
    .ctl_wr, .ctl_sel, .ctl_data, .probe_flag);

  function automatic logic [31:0] pg(input int n, input int off = 0);
    return {n[22:0], 9'(off)};
  endfunction

  function automatic logic [31:0] ent(input bit h, input logic [20:0] f, input bit v, input bit m, input logic [7:0] p);
    return {h, f, v, m, p};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; lk_req = 0; fill_en = 0; ctl_wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic [31:0] va, input logic [20:0] f, input bit v = 1, input bit m = 0, input logic [7:0] p = 8'h11);
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_pfn = f; fill_pv = v; fill_mod = m; fill_prot = p;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic ctl(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1; ctl_sel = s; ctl_data = d;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic look(input logic [31:0] va, output logic [31:0] r);
    @(negedge clk);
    lk_req = 1; lk_va = va;
    @(negedge clk);
    lk_req = 0;
    r = {lk_hit, lk_pfn, lk_pv, lk_mod, lk_prot};
  endtask

  task automatic t_reset();
    logic [31:0] r;
    do_reset();
    chk("R1 probe_flag after reset", {31'd0, probe_flag}, 0);
    look(pg(0), r);
    chk("R1 empty after reset", r, 0);
    ctl(4, pg(0));
    chk("R1 probe finds nothing", {31'd0, probe_flag}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] r;
    do_reset();
    fill(pg(256), 21'h12345, 1, 0, 8'hA5);
    look(pg(256, 9'h1FF), r);
    chk("R2 hit ignores offset", r, ent(1, 21'h12345, 1, 0, 8'hA5));
    look(pg(257), r);
    chk("R3 miss zero", r, 0);
    @(negedge clk);
    chk("R3 no request no hit", {31'd0, lk_hit}, 0);
  endtask

  task automatic t_replace();
    logic [31:0] r;
    do_reset();
    for (int k = 1; k <= 28; k++) fill(pg(k), 21'(k));
    look(pg(28), r);
    chk("R4 last slot filled", r, ent(1, 21'd28, 1, 0, 8'h11));
    look(pg(5), r);
    chk("R2 hit off pointer", r, ent(1, 21'd5, 1, 0, 8'h11));
    fill(pg(100), 21'd100);
    look(pg(1), r);
    chk("R6 wrap evicts entry 0", r, 0);
    look(pg(100), r);
    chk("R4 new fill present", r, ent(1, 21'd100, 1, 0, 8'h11));
    look(pg(2), r);
    chk("R5 hit on pointer", r, ent(1, 21'd2, 1, 0, 8'h11));
    fill(pg(101), 21'd101);
    look(pg(2), r);
    chk("R5 last used survives", r, ent(1, 21'd2, 1, 0, 8'h11));
    look(pg(3), r);
    chk("R5 next entry evicted", r, 0);
    look(pg(5), r);
    chk("R4 other entries kept", r, ent(1, 21'd5, 1, 0, 8'h11));
  endtask

  task automatic t_overwrite();
    logic [31:0] r;
    do_reset();
    fill(pg(10), 21'd1);
    fill(pg(11), 21'd2);
    fill(pg(10, 5), 21'h777, 0, 1, 8'h3C);
    look(pg(10), r);
    chk("R7 overwrite data", r, ent(1, 21'h777, 0, 1, 8'h3C));
    fill(pg(12), 21'd3);
    look(pg(12), r);
    chk("R7 pointer not moved by overwrite", r, ent(1, 21'd3, 1, 0, 8'h11));
    look(pg(11), r);
    chk("R7 neighbour kept", r, ent(1, 21'd2, 1, 0, 8'h11));
    ctl(3, pg(10));
    look(pg(10), r);
    chk("R7 no stale duplicate", r, 0);
  endtask

  task automatic t_flush();
    logic [31:0] r;
    for (int s = 0; s < 3; s++) begin
      do_reset();
      fill(pg(20), 21'd20);
      fill(pg(21), 21'd21);
      ctl(3'(s), 32'hFFFF_FFFF);
      look(pg(20), r);
      chk($sformatf("R8 flush code %0d a", s), r, 0);
      look(pg(21), r);
      chk($sformatf("R8 flush code %0d b", s), r, 0);
    end
    for (int s = 5; s < 8; s++) begin
      do_reset();
      fill(pg(30), 21'd30);
      ctl(3'(s), pg(30));
      look(pg(30), r);
      chk($sformatf("R12 code %0d ignored", s), r, ent(1, 21'd30, 1, 0, 8'h11));
    end
  endtask

  task automatic t_inv_single();
    logic [31:0] r;
    do_reset();
    fill(pg(40), 21'd40);
    fill(pg(41), 21'd41);
    ctl(3, pg(40, 9'h0AB));
    look(pg(40), r);
    chk("R9 target cleared", r, 0);
    look(pg(41), r);
    chk("R9 other kept", r, ent(1, 21'd41, 1, 0, 8'h11));
  endtask

  task automatic t_probe();
    logic [31:0] r;
    do_reset();
    fill(pg(50), 21'd50);
    ctl(4, pg(50, 9'h7));
    chk("R10 probe present", {31'd0, probe_flag}, 1);
    ctl(4, pg(51));
    chk("R10 probe absent", {31'd0, probe_flag}, 0);
    ctl(4, pg(50));
    fill(pg(52), 21'd52);
    look(pg(52), r);
    chk("R10 flag holds", {31'd0, probe_flag}, 1);
    look(pg(50), r);
    chk("R10 probe leaves entry", r, ent(1, 21'd50, 1, 0, 8'h11));
  endtask

  task automatic t_collide();
    logic [31:0] r;
    do_reset();
    fill(pg(60), 21'd60);
    @(negedge clk);
    fill_en = 1; fill_va = pg(61); fill_pfn = 21'd61;
    ctl_wr = 1; ctl_sel = 3; ctl_data = pg(60);
    @(negedge clk);
    fill_en = 0; ctl_wr = 0;
    look(pg(61), r);
    chk("R11 fill dropped on single invalidate", r, 0);
    look(pg(60), r);
    chk("R11 invalidate applied", r, 0);
    @(negedge clk);
    fill_en = 1; fill_va = pg(62); fill_pfn = 21'd62;
    ctl_wr = 1; ctl_sel = 2; ctl_data = 0;
    @(negedge clk);
    fill_en = 0; ctl_wr = 0;
    look(pg(62), r);
    chk("R11 fill dropped on flush", r, 0);
  endtask

  task automatic t_look_fill();
    logic [31:0] r;
    do_reset();
    @(negedge clk);
    fill_en = 1; fill_va = pg(70); fill_pfn = 21'd70; fill_pv = 1; fill_mod = 0; fill_prot = 8'h11;
    lk_req = 1; lk_va = pg(70);
    @(negedge clk);
    fill_en = 0; lk_req = 0;
    chk("R13 lookup sees old contents", {31'd0, lk_hit}, 0);
    look(pg(70), r);
    chk("R13 fill visible after", r, ent(1, 21'd70, 1, 0, 8'h11));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_replace();
    t_overwrite();
    t_flush();
    t_inv_single();
    t_probe();
    t_collide();
    t_look_fill();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule